// File: doc/BRIEF.md
# Registered Word-Pairing Bus Transceiver

This block joins a 12-bit narrow port (A) to a 24-bit wide port made of two 12-bit halves (B1 and B2). Going from narrow to wide, each half has its own capture register with its own active-low load enable. A user loads two successive narrow words, one into each half, and the two halves are then presented side by side as one wide word. Going from wide to narrow, a single return register takes one of the two halves on each clock, chosen by a select input, and drives the narrow port from that register.

Each port is modelled as a data-out bus and an active-high drive flag instead of a tri-state pin. The three active-low output-enable inputs pass through a control register, so a port starts or stops driving only on a clock edge. Disabling a port does not touch the register behind it. A synchronous active-high reset clears every data register and turns every drive flag off.

Top module: `wpair_xcvr`

## Requirements
- R1: While `rst` is high at a rising edge, after that edge `a_out`, `b1_out` and `b2_out` are all zero and `a_oe`, `b1_oe` and `b2_oe` are all 0.
- R2: At a rising edge where `cken1_n` is 0, `b1_out` takes the value `a_in` had at that edge.
- R3: At a rising edge where `cken2_n` is 0, `b2_out` takes the value `a_in` had at that edge.
- R4: At a rising edge where a half's load enable is 1, that half's output is unchanged. Both enables low at the same edge load the same word into both halves.
- R5: At a rising edge where `sel` is 1, `a_out` takes the value `b1_in` had at that edge.
- R6: At a rising edge where `sel` is 0, `a_out` takes the value `b2_in` had at that edge.
- R7: After each rising edge, `a_oe` equals the inverse of the `oea_n` value sampled at that edge.
- R8: After each rising edge, `b1_oe` equals the inverse of the sampled `oeb1_n`, and `b2_oe` equals the inverse of the sampled `oeb2_n`. The two halves are controlled independently.
- R9: A port whose drive flag is 0 keeps its register contents. Its data-out bus still shows the stored value, and the value is unchanged once the port is enabled again.
- R10: All three drive flags may be 1 at once, and in that cycle both transfer directions load as R2, R3, R5 and R6 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register captures on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 12 | Data sampled from the narrow port |
| b1_in | input | 12 | Data sampled from the low half of the wide port |
| b2_in | input | 12 | Data sampled from the high half of the wide port |
| cken1_n | input | 1 | Active-low load enable of the low-half register |
| cken2_n | input | 1 | Active-low load enable of the high-half register |
| sel | input | 1 | Return select: 1 picks b1_in, 0 picks b2_in |
| oea_n | input | 1 | Active-low output enable of the narrow port |
| oeb1_n | input | 1 | Active-low output enable of the low half |
| oeb2_n | input | 1 | Active-low output enable of the high half |
| a_out | output | 12 | Return register value for the narrow port |
| a_oe | output | 1 | Narrow port drive flag (registered) |
| b1_out | output | 12 | Low-half register value |
| b1_oe | output | 1 | Low-half drive flag (registered) |
| b2_out | output | 12 | High-half register value |
| b2_oe | output | 1 | High-half drive flag (registered) |

## Verification
The properties assume that every input is at a known level at each rising edge, including the enables and the select during reset, because each property compares an output with a `$past` input value. The bench drives every input from one task on the falling edge, so each input is stable and defined across the next rising edge. It asserts reset at time zero, before the first edge that a property looks back to. Load patterns, select values and enable combinations are chosen so that held, loaded, disabled and simultaneous-drive cases each occur at least once.

// File: rtl/wpair_pkg.sv
package wpair_pkg;
  localparam int WPAIR_W = 12;

  // registered drive flags, one per port segment
  typedef struct packed {
    logic a;
    logic b1;
    logic b2;
  } wpair_oe_t;

  localparam wpair_oe_t WPAIR_OE_OFF = '{a: 1'b0, b1: 1'b0, b2: 1'b0};
endpackage

// File: rtl/wpair_half_reg.sv
module wpair_half_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/wpair_ret_reg.sv
module wpair_ret_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pick_hi,
  input  logic [W-1:0] d_hi,
  input  logic [W-1:0] d_lo,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb nxt = pick_hi ? d_hi : d_lo;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/wpair_oe_reg.sv
module wpair_oe_reg
  import wpair_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  wpair_oe_t en_n,
  output wpair_oe_t oe
);
  always_ff @(posedge clk) begin
    if (rst) oe <= WPAIR_OE_OFF;
    else     oe <= ~en_n;
  end
endmodule

// File: rtl/wpair_xcvr.sv
module wpair_xcvr
  import wpair_pkg::*;
#(
  parameter int W = WPAIR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  input  logic         cken1_n,
  input  logic         cken2_n,
  input  logic         sel,
  input  logic         oea_n,
  input  logic         oeb1_n,
  input  logic         oeb2_n,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b1_out,
  output logic         b1_oe,
  output logic [W-1:0] b2_out,
  output logic         b2_oe
);
  localparam int NH = 2;

  logic [NH-1:0]        half_ld;
  logic [NH-1:0][W-1:0] half_q;
  wpair_oe_t            oe_n_d;
  wpair_oe_t            oe_q;

  assign half_ld = {~cken2_n, ~cken1_n};

  // one capture register per wide-port half, all fed from the narrow port
  for (genvar g = 0; g < NH; g++) begin : g_half
    wpair_half_reg #(.W(W)) u_half (
      .clk (clk),
      .rst (rst),
      .ld  (half_ld[g]),
      .d   (a_in),
      .q   (half_q[g])
    );
  end

  assign b1_out = half_q[0];
  assign b2_out = half_q[1];

  wpair_ret_reg #(.W(W)) u_ret (
    .clk     (clk),
    .rst     (rst),
    .pick_hi (sel),
    .d_hi    (b1_in),
    .d_lo    (b2_in),
    .q       (a_out)
  );

  assign oe_n_d = '{a: oea_n, b1: oeb1_n, b2: oeb2_n};

  wpair_oe_reg u_oe (
    .clk  (clk),
    .rst  (rst),
    .en_n (oe_n_d),
    .oe   (oe_q)
  );

  assign a_oe  = oe_q.a;
  assign b1_oe = oe_q.b1;
  assign b2_oe = oe_q.b2;
endmodule

// File: rtl/wpair_xcvr_chk.sv
module wpair_xcvr_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b1_in,
  input logic [W-1:0] b2_in,
  input logic         cken1_n,
  input logic         cken2_n,
  input logic         sel,
  input logic         oea_n,
  input logic         oeb1_n,
  input logic         oeb2_n,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b1_out,
  input logic         b1_oe,
  input logic [W-1:0] b2_out,
  input logic         b2_oe
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (a_out == '0 && b1_out == '0 && b2_out == '0 && !a_oe && !b1_oe && !b2_oe));

  a_r2_low_load: assert property (@(posedge clk) disable iff (rst)
    !cken1_n |=> b1_out == $past(a_in));

  a_r3_high_load: assert property (@(posedge clk) disable iff (rst)
    !cken2_n |=> b2_out == $past(a_in));

  a_r4_low_hold: assert property (@(posedge clk) disable iff (rst)
    cken1_n |=> $stable(b1_out));

  a_r4_high_hold: assert property (@(posedge clk) disable iff (rst)
    cken2_n |=> $stable(b2_out));

  a_r5_pick_low_half: assert property (@(posedge clk) disable iff (rst)
    sel |=> a_out == $past(b1_in));

  a_r6_pick_high_half: assert property (@(posedge clk) disable iff (rst)
    !sel |=> a_out == $past(b2_in));

  a_r7_narrow_drive: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> a_oe == !$past(oea_n));

  a_r8_low_drive: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> b1_oe == !$past(oeb1_n));

  a_r8_high_drive: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> b2_oe == !$past(oeb2_n));

  a_r10_both_ways: assert property (@(posedge clk) disable iff (rst)
    (!oea_n && !oeb1_n && !oeb2_n) |=> (a_oe && b1_oe && b2_oe));
endmodule

bind wpair_xcvr wpair_xcvr_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .a_in    (a_in),
  .b1_in   (b1_in),
  .b2_in   (b2_in),
  .cken1_n (cken1_n),
  .cken2_n (cken2_n),
  .sel     (sel),
  .oea_n   (oea_n),
  .oeb1_n  (oeb1_n),
  .oeb2_n  (oeb2_n),
  .a_out   (a_out),
  .a_oe    (a_oe),
  .b1_out  (b1_out),
  .b1_oe   (b1_oe),
  .b2_out  (b2_out),
  .b2_oe   (b2_oe)
);

// File: tb/wpair_xcvr_bench.sv
module wpair_xcvr_bench;
  localparam int W = 12;

  typedef struct packed {
    logic         rst_f;
    logic         sel_f;
    logic         ld1;
    logic         ld2;
    logic [W-1:0] a;
    logic [W-1:0] b1;
    logic [W-1:0] b2;
    logic         oa;
    logic         ob1;
    logic         ob2;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic         cken1_n = 1'b1, cken2_n = 1'b1, sel = 1'b0;
  logic         oea_n = 1'b1, oeb1_n = 1'b1, oeb2_n = 1'b1;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic         a_oe, b1_oe, b2_oe;

  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;
  exp_t q_exp[$];

  logic [W-1:0] m_a = '0, m_b1 = '0, m_b2 = '0;

  always #5 clk = ~clk;

  wpair_xcvr #(.W(W)) u_wpair_xcvr (
    .clk(clk), .rst(rst), .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
    .cken1_n(cken1_n), .cken2_n(cken2_n), .sel(sel),
    .oea_n(oea_n), .oeb1_n(oeb1_n), .oeb2_n(oeb2_n),
    .a_out(a_out), .a_oe(a_oe), .b1_out(b1_out), .b1_oe(b1_oe),
    .b2_out(b2_out), .b2_oe(b2_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected result
  task automatic step(input logic r, input logic [W-1:0] a, input logic [W-1:0] h1,
                      input logic [W-1:0] h2, input logic c1n, input logic c2n,
                      input logic s, input logic ean, input logic e1n, input logic e2n);
    exp_t e;
    @(negedge clk);
    rst = r; a_in = a; b1_in = h1; b2_in = h2;
    cken1_n = c1n; cken2_n = c2n; sel = s;
    oea_n = ean; oeb1_n = e1n; oeb2_n = e2n;
    if (r) begin
      m_a = '0; m_b1 = '0; m_b2 = '0;
    end else begin
      if (!c1n) m_b1 = a;
      if (!c2n) m_b2 = a;
      m_a = s ? h1 : h2;
    end
    e.rst_f = r; e.sel_f = s; e.ld1 = !c1n; e.ld2 = !c2n;
    e.a = m_a; e.b1 = m_b1; e.b2 = m_b2;
    e.oa  = r ? 1'b0 : !ean;
    e.ob1 = r ? 1'b0 : !e1n;
    e.ob2 = r ? 1'b0 : !e2n;
    q_exp.push_back(e);
  endtask

  // monitor: compare outputs a little after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_exp.size() > 0) begin
        exp_t e;
        string tb1, tb2, ta, to;
        e = q_exp.pop_front();
        if (e.rst_f) begin
          tb1 = "R1"; tb2 = "R1"; ta = "R1"; to = "R1";
        end else begin
          tb1 = e.ld1 ? "R2" : (!e.ob1 ? "R9" : "R4");
          tb2 = e.ld2 ? "R3" : (!e.ob2 ? "R9" : "R4");
          ta  = !e.oa ? "R9" : (e.sel_f ? "R5" : "R6");
          to  = (e.oa && e.ob1 && e.ob2) ? "R10" : "R7";
        end
        check({tb1, " b1_out"}, 32'(b1_out), 32'(e.b1));
        check({tb2, " b2_out"}, 32'(b2_out), 32'(e.b2));
        check({ta, " a_out"}, 32'(a_out), 32'(e.a));
        check({to, " a_oe"}, 32'(a_oe), 32'(e.oa));
        check({e.rst_f ? "R1" : "R8", " b1_oe"}, 32'(b1_oe), 32'(e.ob1));
        check({e.rst_f ? "R1" : "R8", " b2_oe"}, 32'(b2_oe), 32'(e.ob2));
      end
    end
  end

  initial begin
    // R1: reset with non-zero data and all enables asserted
    step(1, 12'hAAA, 12'h555, 12'h333, 0, 0, 1, 0, 0, 0);
    step(1, 12'h123, 12'h456, 12'h789, 0, 0, 0, 0, 0, 0);
    // R2: load low half only, narrow port enabled, sel=1 (R5)
    step(0, 12'h1A1, 12'h0F0, 12'hF0F, 0, 1, 1, 0, 1, 1);
    // R3: load high half only, sel=0 (R6)
    step(0, 12'h2B2, 12'h111, 12'h222, 1, 0, 0, 0, 1, 1);
    // R4: both held, B halves driven independently (R8)
    step(0, 12'hFFF, 12'h333, 12'h444, 1, 1, 1, 1, 0, 1);
    step(0, 12'h000, 12'h555, 12'h666, 1, 1, 0, 1, 1, 0);
    // R4: both load the same word
    step(0, 12'hC3C, 12'h777, 12'h888, 0, 0, 1, 0, 0, 0);
    // R10: all drive flags on, both directions load
    step(0, 12'h5A5, 12'h999, 12'hABC, 0, 1, 0, 0, 0, 0);
    step(0, 12'hA5A, 12'hDEF, 12'h135, 1, 0, 1, 0, 0, 0);
    // R9: all ports disabled, registers hold, data-out still shows contents
    step(0, 12'h777, 12'h246, 12'h8AC, 1, 1, 1, 1, 1, 1);
    step(0, 12'h888, 12'h246, 12'h8AC, 1, 1, 1, 1, 1, 1);
    // R9: re-enable, stored halves unchanged
    step(0, 12'h999, 12'h246, 12'h8AC, 1, 1, 1, 0, 0, 0);
    // sequence of pairings with alternating select
    for (int i = 0; i < 16; i++) begin
      step(0, 12'(i * 37 + 5), 12'(i * 91), 12'(~(i * 13)),
           i[0], !i[0], i[1], i[2], i[3], !i[2]);
    end
    // R1: reset mid-run, then resume
    step(1, 12'hEEE, 12'hDDD, 12'hCCC, 0, 0, 1, 0, 0, 0);
    step(0, 12'h0AB, 12'h0CD, 12'h0EF, 0, 1, 0, 0, 0, 0);
    step(0, 12'h000, 12'h000, 12'h000, 1, 1, 1, 1, 1, 1);
    while (q_exp.size() > 0) @(posedge clk);
    @(posedge clk);
    #3;
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=expired expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule